// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block sits in the command path of a double-data-rate memory controller. It holds the burst settings from the mode register and generates a column address for every beat of a read or write burst. A mode-register write carries a two-bit register select and an address word. Select 00 programs the main register: burst length, wrap order and CAS latency. Select 01 programs the extended register: DLL disable and half drive strength. Those two extended bits are stored but change nothing the block produces.

When an access starts, the sequencer loads the start column. Each beat strobe then moves it to the next column of the burst. Only the low bits inside the burst-length window change, and they wrap inside that window in either sequential or interleaved order. A last-beat flag marks the final column, and the next strobe returns the sequencer to idle. Main-register writes that carry a reserved code are refused. The previous settings stay in force and an error level goes high.

Top module: `burst_col_seq`

## Requirements
- R1: After reset: burst_len reads 2, cas_lat_x2 reads 4 (latency 2), the wrap order is sequential, mr_err is 0, and col_valid and last_beat are 0.
- R2: A main-register write (mr_sel = 00) takes the burst-length code from data bits [2:0]: 001 gives 2, 010 gives 4, 011 gives 8. burst_len shows the new value in the cycle after the write.
- R3: In the same write, data bits [6:4] set the CAS latency, reported in half cycles on cas_lat_x2: code 010 gives 4 (latency 2) and code 110 gives 5 (latency 2.5).
- R4: A main-register write is refused as a whole when its burst-length code or latency code is reserved, or when any data bit from bit 7 upward is 1. A refused write leaves burst_len, cas_lat_x2 and the wrap order unchanged and sets mr_err. The next accepted main-register write clears mr_err.
- R5: An extended-register write (mr_sel = 01) stores data bit 0 (DLL disable) and data bit 1 (half drive) and changes no output. A write with mr_sel = 10 or 11 is ignored.
- R6: An access start makes col_valid 1 and col_out equal to acc_col in the next cycle. A start during a burst abandons that burst and begins the new one.
- R7: With data bit 3 = 0 (sequential), beat i of a burst of length BL from start column S has the low log2(BL) bits equal to (S + i) mod BL, with no carry into the upper bits. All other bits equal those of S.
- R8: With data bit 3 = 1 (interleaved), beat i has the low log2(BL) bits equal to the low bits of S XOR i. All other bits equal those of S.
- R9: last_beat is 1 exactly while beat BL-1 is shown. A beat strobe in that cycle makes col_valid and last_beat 0. A beat strobe while idle changes nothing.
- R10: A burst keeps the length and order that were in force when it started, even if the mode register is rewritten during the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mr_wr | input | 1 | Mode-register write strobe |
| mr_sel | input | 2 | Register select: 00 main, 01 extended |
| mr_data | input | MR_W | Mode-register address word |
| acc_start | input | 1 | Start of an access |
| acc_col | input | COL_W | Start column of the access |
| beat_adv | input | 1 | Advance to the next beat |
| col_out | output | COL_W | Column of the current beat |
| col_valid | output | 1 | A burst is in progress |
| last_beat | output | 1 | The current beat is the last one |
| burst_len | output | 4 | Decoded burst length (2, 4 or 8) |
| cas_lat_x2 | output | 3 | Decoded CAS latency in half cycles |
| mr_err | output | 1 | Last main-register write was refused |

## Verification
The hardest case to reach is a mode-register rewrite that lands in the middle of a burst that is already under way. If the sequencer read the live settings instead of the ones it captured at the start, the burst would end early or wrap differently. The bench starts an 8-beat sequential burst and advances two beats. It then writes a 2-beat interleaved setting between beat strobes and checks that the remaining beats still follow the 8-beat sequential order. It also checks that the last-beat flag appears only on the eighth beat.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int LOW_W  = 3;   // widest wrap window (8 beats)
  localparam int BLEN_W = 4;
  localparam int CLX2_W = 3;
  localparam int SEL_W  = 2;

  localparam logic [SEL_W-1:0] SEL_MAIN = 2'b00;
  localparam logic [SEL_W-1:0] SEL_EXT  = 2'b01;

  typedef enum logic {ORD_SEQ = 1'b0, ORD_ILV = 1'b1} wrap_ord_e;

  // burst-length code -> wrap mask; zero marks a reserved code
  function automatic logic [LOW_W-1:0] bl_code_mask(input logic [2:0] code);
    case (code)
      3'b001:  return 3'b001;
      3'b010:  return 3'b011;
      3'b011:  return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  // latency code -> half-cycle count; zero marks a reserved code
  function automatic logic [CLX2_W-1:0] cl_code_x2(input logic [2:0] code);
    case (code)
      3'b010:  return 3'd4;
      3'b110:  return 3'd5;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
  import bcs_pkg::*;
#(
  parameter int MR_W = 13
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mr_wr,
  input  logic [SEL_W-1:0]    mr_sel,
  input  logic [MR_W-1:0]     mr_data,
  output logic [LOW_W-1:0]    cfg_mask,
  output wrap_ord_e           cfg_ord,
  output logic [BLEN_W-1:0]   burst_len,
  output logic [CLX2_W-1:0]   cas_lat_x2,
  output logic                mr_err
);
  localparam int RSV_LO = 7;

  logic [LOW_W-1:0]  new_mask;
  logic [CLX2_W-1:0] new_clx2;
  logic              rsv_clear;
  logic              main_wr, ext_wr, accept;
  logic              dll_off_q, drv_half_q;

  assign new_mask  = bl_code_mask(mr_data[2:0]);
  assign new_clx2  = cl_code_x2(mr_data[6:4]);
  assign rsv_clear = (mr_data[MR_W-1:RSV_LO] == '0);
  assign main_wr   = mr_wr && (mr_sel == SEL_MAIN);
  assign ext_wr    = mr_wr && (mr_sel == SEL_EXT);
  assign accept    = main_wr && (new_mask != '0) && (new_clx2 != '0) && rsv_clear;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_mask   <= 3'b001;
      cfg_ord    <= ORD_SEQ;
      burst_len  <= BLEN_W'(2);
      cas_lat_x2 <= 3'd4;
      mr_err     <= 1'b0;
      dll_off_q  <= 1'b0;
      drv_half_q <= 1'b0;
    end else begin
      if (accept) begin
        cfg_mask   <= new_mask;
        cfg_ord    <= wrap_ord_e'(mr_data[3]);
        burst_len  <= BLEN_W'({1'b0, new_mask}) + BLEN_W'(1);
        cas_lat_x2 <= new_clx2;
        mr_err     <= 1'b0;
      end else if (main_wr) begin
        mr_err     <= 1'b1;
      end
      if (ext_wr) begin
        dll_off_q  <= mr_data[0];
        drv_half_q <= mr_data[1];
      end
    end
  end

  AST_BL_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (burst_len == 4'd2) || (burst_len == 4'd4) || (burst_len == 4'd8)); // R2

  AST_CL_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (cas_lat_x2 == 3'd4) || (cas_lat_x2 == 3'd5)); // R3

  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (main_wr && !accept) |=> ($stable(burst_len) && $stable(cas_lat_x2) && mr_err)); // R4

  AST_EXT_LATCH: assert property (@(posedge clk) disable iff (rst)
    ext_wr |=> (dll_off_q == $past(mr_data[0]) && drv_half_q == $past(mr_data[1])
                && $stable(burst_len) && $stable(cas_lat_x2))); // R5
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
  import bcs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base_col,
  input  logic [LOW_W-1:0] beat_idx,
  input  logic [LOW_W-1:0] wrap_mask,
  input  wrap_ord_e        wrap_ord,
  output logic [COL_W-1:0] beat_col
);
  logic [LOW_W-1:0] seq_low, ilv_low, mix_low;

  assign seq_low = base_col[LOW_W-1:0] + beat_idx;
  assign ilv_low = base_col[LOW_W-1:0] ^ beat_idx;
  assign mix_low = (wrap_ord == ORD_ILV) ? ilv_low : seq_low;

  for (genvar b = 0; b < LOW_W; b++) begin : g_low
    assign beat_col[b] = wrap_mask[b] ? mix_low[b] : base_col[b];
  end

  if (COL_W > LOW_W) begin : g_high
    assign beat_col[COL_W-1:LOW_W] = base_col[COL_W-1:LOW_W];
  end
endmodule

// File: rtl/bcs_beat_ctrl.sv
module bcs_beat_ctrl
  import bcs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_start,
  input  logic [COL_W-1:0] acc_col,
  input  logic             beat_adv,
  input  logic [LOW_W-1:0] cfg_mask,
  input  wrap_ord_e        cfg_ord,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             last_beat
);
  logic [COL_W-1:0] base_q, nx_base, gen_col;
  logic [LOW_W-1:0] beat_q, nx_beat, mask_q, nx_mask;
  wrap_ord_e        ord_q, nx_ord;
  logic             load, finish;

  always_comb begin
    nx_base = base_q;
    nx_beat = beat_q;
    nx_mask = mask_q;
    nx_ord  = ord_q;
    load    = 1'b0;
    finish  = 1'b0;
    if (acc_start) begin
      nx_base = acc_col;
      nx_beat = '0;
      nx_mask = cfg_mask;
      nx_ord  = cfg_ord;
      load    = 1'b1;
    end else if (col_valid && beat_adv) begin
      if (last_beat) begin
        finish  = 1'b1;
      end else begin
        nx_beat = beat_q + LOW_W'(1);
        load    = 1'b1;
      end
    end
  end

  bcs_addr_gen #(.COL_W(COL_W)) u_gen (
    .base_col  (nx_base),
    .beat_idx  (nx_beat),
    .wrap_mask (nx_mask),
    .wrap_ord  (nx_ord),
    .beat_col  (gen_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q    <= '0;
      beat_q    <= '0;
      mask_q    <= 3'b001;
      ord_q     <= ORD_SEQ;
      col_out   <= '0;
      col_valid <= 1'b0;
      last_beat <= 1'b0;
    end else begin
      base_q <= nx_base;
      beat_q <= nx_beat;
      mask_q <= nx_mask;
      ord_q  <= nx_ord;
      if (load) begin
        col_out   <= gen_col;
        col_valid <= 1'b1;
        last_beat <= (nx_beat == nx_mask);
      end else if (finish) begin
        col_valid <= 1'b0;
        last_beat <= 1'b0;
      end
    end
  end

  AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
    acc_start |=> (col_valid && col_out == $past(acc_col))); // R6

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    last_beat |-> col_valid); // R9

  AST_LAST_THEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (last_beat && beat_adv && !acc_start) |=> !col_valid); // R9

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (!col_valid && !acc_start) |=> !col_valid); // R9

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
    (col_valid && !acc_start) |=>
      (col_out[COL_W-1:LOW_W] == $past(col_out[COL_W-1:LOW_W]))); // R7
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W = 10,
  parameter int MR_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mr_wr,
  input  logic [1:0]        mr_sel,
  input  logic [MR_W-1:0]   mr_data,
  input  logic              acc_start,
  input  logic [COL_W-1:0]  acc_col,
  input  logic              beat_adv,
  output logic [COL_W-1:0]  col_out,
  output logic              col_valid,
  output logic              last_beat,
  output logic [3:0]        burst_len,
  output logic [2:0]        cas_lat_x2,
  output logic              mr_err
);
  logic [LOW_W-1:0] cfg_mask;
  wrap_ord_e        cfg_ord;

  bcs_mode_reg #(.MR_W(MR_W)) u_mode (
    .clk        (clk),
    .rst        (rst),
    .mr_wr      (mr_wr),
    .mr_sel     (mr_sel),
    .mr_data    (mr_data),
    .cfg_mask   (cfg_mask),
    .cfg_ord    (cfg_ord),
    .burst_len  (burst_len),
    .cas_lat_x2 (cas_lat_x2),
    .mr_err     (mr_err)
  );

  bcs_beat_ctrl #(.COL_W(COL_W)) u_beat (
    .clk       (clk),
    .rst       (rst),
    .acc_start (acc_start),
    .acc_col   (acc_col),
    .beat_adv  (beat_adv),
    .cfg_mask  (cfg_mask),
    .cfg_ord   (cfg_ord),
    .col_out   (col_out),
    .col_valid (col_valid),
    .last_beat (last_beat)
  );
endmodule

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;
  localparam int COL_W = 10;
  localparam int MR_W  = 13;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             mr_wr = 1'b0;
  logic [1:0]       mr_sel = 2'b00;
  logic [MR_W-1:0]  mr_data = '0;
  logic             acc_start = 1'b0;
  logic [COL_W-1:0] acc_col = '0;
  logic             beat_adv = 1'b0;
  logic [COL_W-1:0] col_out;
  logic             col_valid, last_beat, mr_err;
  logic [3:0]       burst_len;
  logic [2:0]       cas_lat_x2;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W), .MR_W(MR_W)) u_dut (
    .clk(clk), .rst(rst), .mr_wr(mr_wr), .mr_sel(mr_sel), .mr_data(mr_data),
    .acc_start(acc_start), .acc_col(acc_col), .beat_adv(beat_adv),
    .col_out(col_out), .col_valid(col_valid), .last_beat(last_beat),
    .burst_len(burst_len), .cas_lat_x2(cas_lat_x2), .mr_err(mr_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [MR_W-1:0] enc(input int bl, input bit ilv, input logic [2:0] cl);
    logic [2:0] blc;
    blc = (bl == 2) ? 3'b001 : (bl == 4) ? 3'b010 : 3'b011;
    return MR_W'({cl, ilv, blc});
  endfunction

  function automatic int exp_col(input int s, input int bl, input bit ilv, input int i);
    int lo;
    lo = s % bl;
    return (s - lo) + (ilv ? (lo ^ i) : ((lo + i) % bl));
  endfunction

  task automatic mrs(input logic [1:0] sel, input logic [MR_W-1:0] d);
    @(negedge clk); mr_wr = 1'b1; mr_sel = sel; mr_data = d;
    @(negedge clk); mr_wr = 1'b0; mr_sel = 2'b00; mr_data = '0;
  endtask

  task automatic start(input int s);
    @(negedge clk); acc_start = 1'b1; acc_col = COL_W'(s);
    @(negedge clk); acc_start = 1'b0;
  endtask

  task automatic adv();
    @(negedge clk); beat_adv = 1'b1;
    @(negedge clk); beat_adv = 1'b0;
  endtask

  // full burst: start, every beat, then return to idle
  task automatic run_burst(input int s, input int bl, input bit ilv, input string req);
    start(s);
    check(col_valid == 1'b1, "R6 valid after start", col_valid, 1);
    check(col_out == COL_W'(s), "R6 start column", col_out, s);
    for (int i = 1; i < bl; i++) begin
      adv();
      check(col_out == COL_W'(exp_col(s, bl, ilv, i)), req, col_out, exp_col(s, bl, ilv, i));
      check(last_beat == (i == bl - 1), "R9 last flag", last_beat, int'(i == bl - 1));
    end
    adv();
    check(col_valid == 1'b0, "R9 idle after last", col_valid, 0);
  endtask

  task automatic t_reset();
    check(burst_len == 4'd2, "R1 burst_len", burst_len, 2);
    check(cas_lat_x2 == 3'd4, "R1 cas", cas_lat_x2, 4);
    check(mr_err == 1'b0, "R1 err", mr_err, 0);
    check(col_valid == 1'b0 && last_beat == 1'b0, "R1 idle", col_valid, 0);
    run_burst(10'h2B5, 2, 1'b0, "R1 default sequential BL2");
  endtask

  task automatic t_decode();
    mrs(2'b00, enc(8, 1'b0, 3'b110));
    check(burst_len == 4'd8, "R2 BL8", burst_len, 8);
    check(cas_lat_x2 == 3'd5, "R3 CL2.5", cas_lat_x2, 5);
    mrs(2'b00, enc(4, 1'b0, 3'b010));
    check(burst_len == 4'd4, "R2 BL4", burst_len, 4);
    check(cas_lat_x2 == 3'd4, "R3 CL2", cas_lat_x2, 4);
    check(mr_err == 1'b0, "R2 no err", mr_err, 0);
  endtask

  task automatic t_reserved();
    mrs(2'b00, MR_W'(13'h0020));   // BL code 000
    check(mr_err == 1'b1, "R4 bad BL err", mr_err, 1);
    check(burst_len == 4'd4, "R4 BL kept", burst_len, 4);
    mrs(2'b00, MR_W'(13'h0013));   // CL code 001
    check(mr_err == 1'b1, "R4 bad CL err", mr_err, 1);
    check(cas_lat_x2 == 3'd4, "R4 CL kept", cas_lat_x2, 4);
    mrs(2'b00, enc(8, 1'b1, 3'b110) | MR_W'(13'h0080));  // bit 7 set
    check(mr_err == 1'b1, "R4 rsv bit err", mr_err, 1);
    check(burst_len == 4'd4 && cas_lat_x2 == 3'd4, "R4 rsv kept", burst_len, 4);
    run_burst(10'h0F6, 4, 1'b0, "R4 order kept sequential");
    mrs(2'b00, enc(4, 1'b0, 3'b010));
    check(mr_err == 1'b0, "R4 err cleared", mr_err, 0);
  endtask

  task automatic t_ext();
    mrs(2'b01, MR_W'(13'h006B));
    check(burst_len == 4'd4 && cas_lat_x2 == 3'd4 && mr_err == 1'b0, "R5 ext no effect",
          burst_len, 4);
    mrs(2'b10, enc(8, 1'b1, 3'b110));
    mrs(2'b11, MR_W'(13'h1FFF));
    check(burst_len == 4'd4 && cas_lat_x2 == 3'd4 && mr_err == 1'b0, "R5 sel 1x ignored",
          burst_len, 4);
    run_burst(10'h13E, 4, 1'b0, "R5 burst unchanged");
  endtask

  task automatic t_orders();
    mrs(2'b00, enc(8, 1'b0, 3'b010));
    run_burst(10'h2B5, 8, 1'b0, "R7 sequential BL8");
    mrs(2'b00, enc(4, 1'b1, 3'b010));
    run_burst(10'h0F6, 4, 1'b1, "R8 interleave BL4");
    mrs(2'b00, enc(8, 1'b1, 3'b110));
    run_burst(10'h3FB, 8, 1'b1, "R8 interleave BL8");
    mrs(2'b00, enc(2, 1'b1, 3'b010));
    run_burst(10'h101, 2, 1'b1, "R8 interleave BL2");
  endtask

  task automatic t_idle_restart();
    adv();
    check(col_valid == 1'b0, "R9 adv while idle", col_valid, 0);
    mrs(2'b00, enc(8, 1'b0, 3'b010));
    start(10'h050);
    adv();
    check(col_out == 10'h051, "R6 first burst beat", col_out, 10'h051);
    run_burst(10'h1A6, 8, 1'b0, "R6 restart sequence");
  endtask

  task automatic t_freeze();
    start(10'h0CD);
    adv(); adv();
    mrs(2'b00, enc(2, 1'b1, 3'b010));
    check(burst_len == 4'd2, "R10 new setting visible", burst_len, 2);
    check(col_out == COL_W'(exp_col(10'h0CD, 8, 1'b0, 2)), "R10 col held over write",
          col_out, exp_col(10'h0CD, 8, 1'b0, 2));
    for (int i = 3; i < 8; i++) begin
      adv();
      check(col_out == COL_W'(exp_col(10'h0CD, 8, 1'b0, i)), "R10 captured order",
            col_out, exp_col(10'h0CD, 8, 1'b0, i));
      check(last_beat == (i == 7), "R10 captured length", last_beat, int'(i == 7));
    end
    adv();
    check(col_valid == 1'b0, "R10 idle at end", col_valid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_decode();
    t_reserved();
    t_ext();
    t_orders();
    t_idle_restart();
    t_freeze();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule